// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks integer divider settings for a high-speed PHY PLL. Given a target bit rate and a reference frequency, both whole numbers in MHz, it searches the pre-divider values that keep the divided reference inside the allowed comparison window. From those candidates it picks the one whose feedback ratio leaves the smallest truncation remainder. It then returns the chosen pre-divider, the feedback divider, the rate that these values actually produce, and the three bytes that the PHY's divider registers expect.

A one-cycle `start` pulse captures both frequencies. The engine then runs as a multicycle sequence on one shared restoring divider. It makes two divisions to find the window bounds, one division for each candidate, and two more to derive the final feedback value and the achieved rate. `busy` stays high for the whole search. `done` pulses once, in the cycle in which the results become valid. If the reference is too slow to give any legal pre-divider, the engine reports an error instead.

Top module: `pll_div_search`

## Requirements
- R1: A high `start_i` while `busy_o` is low captures `target_i` and `ref_i`, and `busy_o` is high from the next cycle on. A `start_i` pulse while `busy_o` is high has no effect: the run in progress finishes with results computed from the values captured first.
- R2: The pre-divider window has an upper bound of floor(ref/5) and a lower bound of floor(ref/40)+1. Candidates run from the lower bound upward and stop before the upper bound.
- R3: When the upper bound is below the lower bound, the run ends with `err_o`=1 and `prediv_o`, `fbdiv_o` and `rate_o` all 0.
- R4: A candidate p replaces the current best only when (target·p) mod ref is strictly smaller than the best remainder so far and floor(target·p/ref) < 512. On equal remainders the earlier (smaller) candidate is kept.
- R5: The best remainder starts at ref and the best pre-divider starts at 1. If no candidate qualifies, or the window holds none, `prediv_o` is 1.
- R6: `fbdiv_o` = floor(target·prediv/ref) and `rate_o` = floor(ref·fbdiv/prediv). On success `err_o` is 0.
- R7: `prediv_code_o` = (prediv−1) mod 256. `fb_lo_code_o` holds bits 4:0 of (fbdiv−1) with bits 7:5 zero. `fb_hi_code_o` = (((fbdiv−1) >> 5) | 0x80) mod 256, where fbdiv−1 wraps modulo 2^20.
- R8: `done_o` is a single-cycle pulse in the same cycle in which `busy_o` falls. The result outputs hold their values until the next run completes.
- R9: After reset, `busy_o`, `done_o` and `err_o` are 0, and `prediv_o`, `fbdiv_o` and `rate_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (taken only when idle) |
| target_i | input | 12 | Target bit rate, MHz |
| ref_i | input | 10 | Reference frequency, MHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| err_o | output | 1 | No legal pre-divider window |
| prediv_o | output | 8 | Selected pre-divider |
| fbdiv_o | output | 20 | Feedback divider |
| rate_o | output | 20 | Achieved rate, MHz |
| prediv_code_o | output | 8 | Pre-divider register byte |
| fb_lo_code_o | output | 8 | Feedback low register byte |
| fb_hi_code_o | output | 8 | Feedback high register byte |

## Verification
The embedded assertions watch the following on every cycle:
- the captured frequencies stay frozen while a run is active;
- `done` never overlaps `busy` and never lasts two cycles;
- the achieved rate never exceeds the target;
- a pre-divider other than the default always comes with a feedback value below 512;
- the shared divider always leaves a remainder smaller than its divisor.

Some properties need whole-run reference arithmetic, so only the bench scenarios can show them:
- the window bounds;
- the first-smallest-remainder choice and the tie rule;
- the fallback to a pre-divider of 1;
- the exact register byte encodings;
- the fact that a start pulse during a run is ignored.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

   // Comparison-frequency window limits, MHz
   localparam int unsigned CMP_MIN_MHZ = 5;
   localparam int unsigned CMP_MAX_MHZ = 40;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HIBOUND,
      ST_LOBOUND,
      ST_CAND,
      ST_FEEDBK,
      ST_RATE
   } srch_state_t;

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
   parameter int NUM_W = 20,
   parameter int DEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             done_o,
   output logic [NUM_W-1:0] quot_o,
   output logic [DEN_W-1:0] rem_o
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] acc_q;
   logic [NUM_W-1:0] q_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             ge;

   always_comb begin
      trial = {acc_q, q_q[NUM_W-1]};
      ge    = trial >= {1'b0, den_q};
      diff  = trial - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         q_q    <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (go_i) begin
            acc_q <= '0;
            q_q   <= num_i;
            den_q <= den_i;
            cnt_q <= CNT_W'(NUM_W);
            run_q <= 1'b1;
         end else if (run_q) begin
            acc_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            q_q   <= {q_q[NUM_W-2:0], ge};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quot_o = q_q;
   assign rem_o  = acc_q;

   // R6
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && den_q != '0) |-> (rem_o < den_q));

   // R1
   go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> !run_q);

endmodule

// File: rtl/pll_byte_encoder.sv
module pll_byte_encoder #(
   parameter int PRE_W = 8,
   parameter int FB_W  = 20
) (
   input  logic [PRE_W-1:0] prediv_i,
   input  logic [FB_W-1:0]  fbdiv_i,
   output logic [7:0]       pre_code_o,
   output logic [7:0]       lo_code_o,
   output logic [7:0]       hi_code_o
);
   localparam int LO_BITS = 5;

   logic [PRE_W-1:0] pre_m1;
   logic [FB_W-1:0]  fb_m1;
   logic [FB_W-1:0]  fb_up;

   always_comb begin
      pre_m1 = prediv_i - 1'b1;
      fb_m1  = fbdiv_i - 1'b1;
      fb_up  = fb_m1 >> LO_BITS;
   end

   generate
      if (PRE_W >= 8) begin : g_pre_wide
         assign pre_code_o = pre_m1[7:0];
      end else begin : g_pre_narrow
         assign pre_code_o = {{(8-PRE_W){1'b0}}, pre_m1};
      end
   endgenerate

   assign lo_code_o = {3'b000, fb_m1[LO_BITS-1:0]};
   assign hi_code_o = {1'b1, fb_up[6:0]};

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
   import pll_search_pkg::*;
#(
   parameter int TGT_W    = 12,
   parameter int REF_W    = 10,
   parameter int PRE_W    = 8,
   parameter int FB_LIMIT = 512
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [TGT_W-1:0]       target_i,
   input  logic [REF_W-1:0]       ref_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic                   err_o,
   output logic [PRE_W-1:0]       prediv_o,
   output logic [TGT_W+PRE_W-1:0] fbdiv_o,
   output logic [TGT_W+PRE_W-1:0] rate_o,
   output logic [7:0]             prediv_code_o,
   output logic [7:0]             fb_lo_code_o,
   output logic [7:0]             fb_hi_code_o
);
   localparam int NUM_W = TGT_W + PRE_W;
   localparam int DEN_W = REF_W;
   localparam int WIDE_W = NUM_W + REF_W;
   localparam logic [NUM_W-1:0] FB_LIM_V = NUM_W'(FB_LIMIT);

   generate
      if (REF_W < 6) begin : g_bad_ref
         $error("REF_W must hold the window constants");
      end
      if (PRE_W < REF_W - 2) begin : g_bad_pre
         $error("PRE_W too narrow for ref/5");
      end
      if (NUM_W < 13) begin : g_bad_num
         $error("feedback width below register split");
      end
   endgenerate

   srch_state_t      state_q;
   logic             wait_q;
   logic [TGT_W-1:0] tgt_q;
   logic [REF_W-1:0] ref_q;
   logic [PRE_W-1:0] hi_p_q;
   logic [PRE_W-1:0] cur_p_q;
   logic [PRE_W-1:0] best_p_q;
   logic [DEN_W-1:0] best_rem_q;
   logic [NUM_W-1:0] fb_q;

   logic             div_go;
   logic [NUM_W-1:0] div_num;
   logic [DEN_W-1:0] div_den;
   logic             div_done;
   logic [NUM_W-1:0] div_quot;
   logic [DEN_W-1:0] div_rem;

   logic [NUM_W-1:0] cand_prod;
   logic [NUM_W-1:0] best_prod;
   logic [WIDE_W-1:0] rate_prod;
   logic [PRE_W-1:0] lo_p_new;
   logic [PRE_W-1:0] nxt_p;

   always_comb begin
      cand_prod = {{PRE_W{1'b0}}, tgt_q} * {{TGT_W{1'b0}}, cur_p_q};
      best_prod = {{PRE_W{1'b0}}, tgt_q} * {{TGT_W{1'b0}}, best_p_q};
      rate_prod = {{NUM_W{1'b0}}, ref_q} * {{REF_W{1'b0}}, fb_q};
      lo_p_new  = div_quot[PRE_W-1:0] + 1'b1;
      nxt_p     = cur_p_q + 1'b1;
   end

   always_comb begin
      div_num = '0;
      div_den = '0;
      unique case (state_q)
         ST_HIBOUND: begin
            div_num = {{(NUM_W-REF_W){1'b0}}, ref_q};
            div_den = DEN_W'(CMP_MIN_MHZ);
         end
         ST_LOBOUND: begin
            div_num = {{(NUM_W-REF_W){1'b0}}, ref_q};
            div_den = DEN_W'(CMP_MAX_MHZ);
         end
         ST_CAND: begin
            div_num = cand_prod;
            div_den = ref_q;
         end
         ST_FEEDBK: begin
            div_num = best_prod;
            div_den = ref_q;
         end
         ST_RATE: begin
            div_num = rate_prod[NUM_W-1:0];
            div_den = {{(DEN_W-PRE_W){1'b0}}, best_p_q};
         end
         default: begin
            div_num = '0;
            div_den = '0;
         end
      endcase
      div_go = (state_q != ST_IDLE) && !wait_q;
   end

   pll_seq_div #(
      .NUM_W(NUM_W),
      .DEN_W(DEN_W)
   ) i_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .num_i  (div_num),
      .den_i  (div_den),
      .done_o (div_done),
      .quot_o (div_quot),
      .rem_o  (div_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         wait_q     <= 1'b0;
         tgt_q      <= '0;
         ref_q      <= '0;
         hi_p_q     <= '0;
         cur_p_q    <= '0;
         best_p_q   <= '0;
         best_rem_q <= '0;
         fb_q       <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         prediv_o   <= '0;
         fbdiv_o    <= '0;
         rate_o     <= '0;
      end else begin
         done_o <= 1'b0;
         if (div_go) begin
            wait_q <= 1'b1;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  tgt_q   <= target_i;
                  ref_q   <= ref_i;
                  wait_q  <= 1'b0;
                  state_q <= ST_HIBOUND;
               end
            end
            ST_HIBOUND: begin
               if (div_done) begin
                  hi_p_q  <= div_quot[PRE_W-1:0];
                  wait_q  <= 1'b0;
                  state_q <= ST_LOBOUND;
               end
            end
            ST_LOBOUND: begin
               if (div_done) begin
                  wait_q     <= 1'b0;
                  cur_p_q    <= lo_p_new;
                  best_p_q   <= PRE_W'(1);
                  best_rem_q <= ref_q;
                  if (hi_p_q < lo_p_new) begin
                     err_o    <= 1'b1;
                     prediv_o <= '0;
                     fbdiv_o  <= '0;
                     rate_o   <= '0;
                     done_o   <= 1'b1;
                     state_q  <= ST_IDLE;
                  end else if (lo_p_new < hi_p_q) begin
                     state_q <= ST_CAND;
                  end else begin
                     state_q <= ST_FEEDBK;
                  end
               end
            end
            ST_CAND: begin
               if (div_done) begin
                  wait_q <= 1'b0;
                  if (div_rem < best_rem_q && div_quot < FB_LIM_V) begin
                     best_p_q   <= cur_p_q;
                     best_rem_q <= div_rem;
                  end
                  cur_p_q <= nxt_p;
                  if (nxt_p >= hi_p_q) begin
                     state_q <= ST_FEEDBK;
                  end
               end
            end
            ST_FEEDBK: begin
               if (div_done) begin
                  fb_q    <= div_quot;
                  wait_q  <= 1'b0;
                  state_q <= ST_RATE;
               end
            end
            ST_RATE: begin
               if (div_done) begin
                  wait_q   <= 1'b0;
                  err_o    <= 1'b0;
                  prediv_o <= best_p_q;
                  fbdiv_o  <= fb_q;
                  rate_o   <= div_quot;
                  done_o   <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);

   pll_byte_encoder #(
      .PRE_W(PRE_W),
      .FB_W (NUM_W)
   ) i_enc (
      .prediv_i   (prediv_o),
      .fbdiv_i    (fbdiv_o),
      .pre_code_o (prediv_code_o),
      .lo_code_o  (fb_lo_code_o),
      .hi_code_o  (fb_hi_code_o)
   );

   // R1
   frozen_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(tgt_q) && $stable(ref_q)));

   // R8
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   rate_below_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (rate_o <= {{PRE_W{1'b0}}, tgt_q}));

   // R4
   fb_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o && prediv_o != PRE_W'(1)) |-> (fbdiv_o < FB_LIM_V));

endmodule

// File: tb/test_pll_div_search.sv
`timescale 1ns/1ps
module test_pll_div_search;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [11:0] target_i = '0;
   logic [9:0]  ref_i = '0;
   logic        busy_o, done_o, err_o;
   logic [7:0]  prediv_o;
   logic [19:0] fbdiv_o, rate_o;
   logic [7:0]  prediv_code_o, fb_lo_code_o, fb_hi_code_o;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pll_div_search i_pll_div_search (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .target_i      (target_i),
      .ref_i         (ref_i),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .err_o         (err_o),
      .prediv_o      (prediv_o),
      .fbdiv_o       (fbdiv_o),
      .rate_o        (rate_o),
      .prediv_code_o (prediv_code_o),
      .fb_lo_code_o  (fb_lo_code_o),
      .fb_hi_code_o  (fb_hi_code_o)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected values from the requirements
   longint e_pre, e_fb, e_rate, e_pcode, e_lo, e_hi;
   bit     e_err;

   task automatic model(input longint t, input longint r);
      longint mx, mn, best, brem, fbm1;
      mx = r / 5;
      mn = r / 40 + 1;
      e_err = (mx < mn);
      if (e_err) begin
         e_pre = 0; e_fb = 0; e_rate = 0;
      end else begin
         best = 1;
         brem = r;
         for (longint p = mn; p < mx; p++) begin
            if (((t * p) % r) < brem && ((t * p) / r) < 512) begin
               best = p;
               brem = (t * p) % r;
            end
         end
         e_pre = best;
         e_fb = (t * best) / r;
         e_rate = (r * e_fb) / best;
      end
      fbm1 = (e_fb - 1) & 64'hFFFFF;
      e_pcode = (e_pre - 1) & 64'hFF;
      e_lo = fbm1 & 64'h1F;
      e_hi = ((fbm1 >> 5) | 64'h80) & 64'hFF;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      finished = 1;
      $finish;
   endtask

   task automatic wait_done(output bit ok);
      int n = 0;
      ok = 1;
      while (!done_o) begin
         @(negedge clk);
         n++;
         if (n > 20000) begin
            check("watchdog R8", 0, 1);
            ok = 0;
            return;
         end
      end
   endtask

   // one search; when dup is set a second start with other values arrives mid-run
   task automatic run(input int t, input int r, input bit dup);
      bit ok;
      @(negedge clk);
      target_i = 12'(t);
      ref_i = 10'(r);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R1 busy after start", busy_o, 1);
      if (dup) begin
         @(negedge clk);
         target_i = 12'(t ^ 12'h5A5);
         ref_i = 10'(r + 37);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      model(t, r);
      wait_done(ok);
      if (!ok) finish_run();
      check("R8 busy low with done", busy_o, 0);
      check("R3 err flag", err_o, e_err);
      check("R2 R4 R5 prediv", prediv_o, e_pre);
      check("R6 fbdiv", fbdiv_o, e_fb);
      check("R6 rate", rate_o, e_rate);
      if (!e_err) begin
         check("R7 prediv code", prediv_code_o, e_pcode);
         check("R7 fb lo code", fb_lo_code_o, e_lo);
         check("R7 fb hi code", fb_hi_code_o, e_hi);
      end
      @(negedge clk);
      check("R8 done single cycle", done_o, 0);
      check("R8 result held", rate_o, e_rate);
      if (dup) check("R1 start during run ignored", busy_o, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         check("watchdog global", 0, 1);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 busy", busy_o, 0);
      check("R9 done", done_o, 0);
      check("R9 err", err_o, 0);
      check("R9 prediv", prediv_o, 0);
      check("R9 fbdiv", fbdiv_o, 0);
      check("R9 rate", rate_o, 0);
      rst_n = 1'b1;

      run(1000, 24, 0);    // R2 narrow window from p=1
      run(1000, 100, 0);   // R4 exact fit at lowest candidate
      run(600, 80, 0);     // R4 ties keep first smallest remainder
      run(4095, 45, 0);    // R4 feedback limit excludes high p
      run(333, 5, 0);      // R5 empty window, default prediv 1
      run(800, 3, 0);      // R3 reference too slow
      run(0, 4, 0);        // R3 boundary just below window
      run(0, 24, 0);       // R7 zero target wraps code bytes
      run(1500, 1023, 0);  // R2 widest window
      run(777, 150, 1);    // R1 second start ignored
      for (int i = 0; i < 18; i++) begin
         run(int'($urandom_range(4095, 1)), int'($urandom_range(400, 1)), (i % 5) == 0);
      end
      finish_run();
   end

endmodule